// File: doc/BRIEF.md
# Speculative load address table

This block remembers loads that were executed early, ahead of stores that might write the same bytes. When such a load runs, the block stores the load's destination register number, its physical byte address and its access size. Every store then compares its own byte range with all remembered loads. Any entry whose bytes overlap the store's bytes is dropped. Later, a check operation names a register. The block answers in the same cycle whether that register's entry is still present. A hit means the early load is still valid. A miss tells the pipeline to branch to its recovery sequence.

Storage is organised as 16 sets of 2 ways. The set is chosen by the low bits of the register number, and the full register number is kept as the tag. One bit per set records which way was filled least recently. A check may optionally consume its entry on a hit. A flush input empties the whole table in one cycle, for use on a context switch.

Top module: `spec_load_table`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every check misses. When a load and a flush arrive in the same cycle, the flush wins and the load leaves no entry.
- R2: A load to register r makes a check of r in any later cycle hit, until that entry is evicted, killed by a store, consumed by a check, or flushed.
- R3: `chkHit` is combinational and reflects the table contents at the start of the current cycle. A load, store, clear or flush in that same cycle does not affect the answer. `chkHit` is 0 whenever `chkValid` is 0.
- R4: The size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An entry covers bytes [addr, addr+size), and a store covers the same kind of range. A store removes every entry whose range shares at least one byte with its own. A store that ends exactly at an entry's first byte, or starts exactly at its end, leaves the entry in place.
- R5: When a load and a store arrive in the same cycle, the store is applied first. The new load's entry survives even if it overlaps the store.
- R6: The set is the register number modulo 16, and the tag compares the full 7-bit register number. Registers that share a set but differ in the upper bits do not hit each other.
- R7: A load to a register that already has a live entry overwrites that entry in place, with the new address and size. The other way of the set is not disturbed.
- R8: A load to a set with no free way evicts the entry that was allocated least recently. The choice of way counts only entries still live after any same-cycle store kill or check clear.
- R9: A hitting check with `chkClear`=1 removes the entry. A check with `chkClear`=0 leaves it in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| ldValid | input | 1 | Speculative load allocates an entry |
| ldReg | input | 7 | Load destination register number |
| ldAddr | input | 32 | Load physical byte address |
| ldSize | input | 2 | Load size code (1/2/4/8 bytes) |
| stValid | input | 1 | Store probes the table |
| stAddr | input | 32 | Store physical byte address |
| stSize | input | 2 | Store size code (1/2/4/8 bytes) |
| chkValid | input | 1 | Check request |
| chkReg | input | 7 | Register number to check |
| chkClear | input | 1 | Consume the entry on a hit |
| chkHit | output | 1 | Entry present (same cycle) |

## Verification
The only output is the check answer. A corrupted valid bit, tag, address range or LRU bit therefore shows up only when a check names the affected register. A lost entry causes a false miss, which costs recovery time. A stale entry causes a false hit, which is a correctness failure. The bench issues checks in almost every cycle and compares each answer with a reference model. A wrong kill, a wrong victim choice or a broken same-cycle ordering is therefore reported at the first check of the register involved, usually one or two cycles after the update that went wrong.

// File: rtl/slt_pkg.sv
package slt_pkg;

  localparam int NUM_WAYS = 2;

  // Update strobes from control to datapath for one cycle.
  typedef struct packed {
    logic flushAll;
    logic killEn;
    logic allocEn;
    logic allocWay;
    logic clrEn;
    logic clrWay;
  } sltStrobe_t;

endpackage

// File: rtl/slt_array.sv
module slt_array
  import slt_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  sltStrobe_t          strobe,
  input  logic [REG_W-1:0]    ldReg,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [1:0]          ldSize,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [1:0]          stSize,
  input  logic [REG_W-1:0]    chkReg,
  output logic [NUM_WAYS-1:0] ldSetValid,
  output logic [NUM_WAYS-1:0] ldSetKill,
  output logic [NUM_WAYS-1:0] ldMatch,
  output logic                ldSetLru,
  output logic [NUM_WAYS-1:0] chkMatch,
  output logic                sameSet
);

  localparam int SET_W = $clog2(NUM_SETS);

  logic                vld   [NUM_SETS][NUM_WAYS];
  logic [REG_W-1:0]    eReg  [NUM_SETS][NUM_WAYS];
  logic [ADDR_W-1:0]   eAddr [NUM_SETS][NUM_WAYS];
  logic [1:0]          eSize [NUM_SETS][NUM_WAYS];
  logic                lruBit[NUM_SETS];
  logic [NUM_WAYS-1:0] ovl   [NUM_SETS];

  logic [SET_W-1:0] ldSet;
  logic [SET_W-1:0] chkSet;

  assign ldSet   = ldReg[SET_W-1:0];
  assign chkSet  = chkReg[SET_W-1:0];
  assign sameSet = (ldSet == chkSet);

  // Byte ranges [aLo, aLo+2^aSz) and [bLo, bLo+2^bSz) share a byte.
  function automatic logic overlaps(input logic [ADDR_W-1:0] aLo, input logic [1:0] aSz,
                                    input logic [ADDR_W-1:0] bLo, input logic [1:0] bSz);
    logic [ADDR_W:0] aLen, bLen, aEnd, bEnd;
    aLen = '0;
    bLen = '0;
    aLen[3:0] = 4'd1 << aSz;
    bLen[3:0] = 4'd1 << bSz;
    aEnd = {1'b0, aLo} + aLen;
    bEnd = {1'b0, bLo} + bLen;
    return ({1'b0, aLo} < bEnd) && ({1'b0, bLo} < aEnd);
  endfunction

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        ovl[s][w] = overlaps(eAddr[s][w], eSize[s][w], stAddr, stSize);
      end
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      ldSetValid[w] = vld[ldSet][w];
      ldSetKill[w]  = ovl[ldSet][w];
      ldMatch[w]    = vld[ldSet][w] && (eReg[ldSet][w] == ldReg);
      chkMatch[w]   = vld[chkSet][w] && (eReg[chkSet][w] == chkReg);
    end
    ldSetLru = lruBit[ldSet];
  end

  // Valid and LRU state: later assignments take priority (kill, clear, alloc).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        lruBit[s] <= 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) vld[s][w] <= 1'b0;
      end
    end else if (strobe.flushAll) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) vld[s][w] <= 1'b0;
      end
    end else begin
      if (strobe.killEn) begin
        for (int s = 0; s < NUM_SETS; s++) begin
          for (int w = 0; w < NUM_WAYS; w++) begin
            if (ovl[s][w]) vld[s][w] <= 1'b0;
          end
        end
      end
      if (strobe.clrEn) vld[chkSet][strobe.clrWay] <= 1'b0;
      if (strobe.allocEn) begin
        vld[ldSet][strobe.allocWay] <= 1'b1;
        lruBit[ldSet]               <= ~strobe.allocWay;
      end
    end
  end

  // Entry payload needs no reset: it is only read behind a valid bit.
  always_ff @(posedge clk) begin
    if (strobe.allocEn && !strobe.flushAll) begin
      eReg [ldSet][strobe.allocWay] <= ldReg;
      eAddr[ldSet][strobe.allocWay] <= ldAddr;
      eSize[ldSet][strobe.allocWay] <= ldSize;
    end
  end

endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
(
  input  logic                flush,
  input  logic                ldValid,
  input  logic                stValid,
  input  logic                chkValid,
  input  logic                chkClear,
  input  logic [NUM_WAYS-1:0] ldSetValid,
  input  logic [NUM_WAYS-1:0] ldSetKill,
  input  logic [NUM_WAYS-1:0] ldMatch,
  input  logic                ldSetLru,
  input  logic [NUM_WAYS-1:0] chkMatch,
  input  logic                sameSet,
  output sltStrobe_t          strobe,
  output logic                chkHit
);

  logic                hit;
  logic                clrEn;
  logic                clrWay;
  logic [NUM_WAYS-1:0] clrHere;
  logic [NUM_WAYS-1:0] live;
  logic [NUM_WAYS-1:0] liveMatch;
  logic                allocWay;

  assign hit    = chkValid && (|chkMatch);
  assign clrEn  = hit && chkClear;
  assign clrWay = chkMatch[1];

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_live
      assign clrHere[w]   = clrEn && sameSet && (clrWay == w[0]);
      assign live[w]      = ldSetValid[w] && !(stValid && ldSetKill[w]) && !clrHere[w];
      assign liveMatch[w] = ldMatch[w] && live[w];
    end
  endgenerate

  // Way choice after this cycle's kills and clears: same register, free way, LRU.
  always_comb begin
    if (|liveMatch)    allocWay = liveMatch[1];
    else if (!live[0]) allocWay = 1'b0;
    else if (!live[1]) allocWay = 1'b1;
    else               allocWay = ldSetLru;
  end

  always_comb begin
    strobe.flushAll = flush;
    strobe.killEn   = stValid;
    strobe.allocEn  = ldValid;
    strobe.allocWay = allocWay;
    strobe.clrEn    = clrEn;
    strobe.clrWay   = clrWay;
  end

  assign chkHit = hit;

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  input  logic              chkClear,
  output logic              chkHit
);

  sltStrobe_t          strobe;
  logic [NUM_WAYS-1:0] ldSetValid;
  logic [NUM_WAYS-1:0] ldSetKill;
  logic [NUM_WAYS-1:0] ldMatch;
  logic                ldSetLru;
  logic [NUM_WAYS-1:0] chkMatch;
  logic                sameSet;

  slt_array #(.NUM_SETS(NUM_SETS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldReg(ldReg), .ldAddr(ldAddr), .ldSize(ldSize),
    .stAddr(stAddr), .stSize(stSize), .chkReg(chkReg),
    .ldSetValid(ldSetValid), .ldSetKill(ldSetKill), .ldMatch(ldMatch),
    .ldSetLru(ldSetLru), .chkMatch(chkMatch), .sameSet(sameSet)
  );

  slt_ctrl u_ctrl (
    .flush(flush), .ldValid(ldValid), .stValid(stValid),
    .chkValid(chkValid), .chkClear(chkClear),
    .ldSetValid(ldSetValid), .ldSetKill(ldSetKill), .ldMatch(ldMatch),
    .ldSetLru(ldSetLru), .chkMatch(chkMatch), .sameSet(sameSet),
    .strobe(strobe), .chkHit(chkHit)
  );

endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              ldValid,
  input logic [REG_W-1:0]  ldReg,
  input logic [ADDR_W-1:0] ldAddr,
  input logic              chkValid,
  input logic [REG_W-1:0]  chkReg,
  input logic              chkClear,
  input logic              chkHit
);

  // R3
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> !chkHit);

  // R1
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !chkHit);

  // R2
  load_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !flush) |=> ((chkValid && chkReg == $past(ldReg)) |-> chkHit));

  // R9
  clear_consumes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkClear && chkHit && !flush && !(ldValid && ldReg == chkReg))
      |=> ((chkValid && chkReg == $past(chkReg)) |-> !chkHit));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    ($past(rstN) == 1'b0 && rstN) |-> !chkHit);

  logic unusedAddr;
  assign unusedAddr = ^ldAddr;

endmodule

bind spec_load_table slt_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .ldValid(ldValid), .ldReg(ldReg),
  .ldAddr(ldAddr), .chkValid(chkValid), .chkReg(chkReg), .chkClear(chkClear),
  .chkHit(chkHit)
);

// File: tb/tb_spec_load_table.sv
module tb_spec_load_table;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        ldValid = 1'b0;
  logic [6:0]  ldReg = '0;
  logic [31:0] ldAddr = '0;
  logic [1:0]  ldSize = '0;
  logic        stValid = 1'b0;
  logic [31:0] stAddr = '0;
  logic [1:0]  stSize = '0;
  logic        chkValid = 1'b0;
  logic [6:0]  chkReg = '0;
  logic        chkClear = 1'b0;
  logic        chkHit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spec_load_table dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .ldValid(ldValid), .ldReg(ldReg), .ldAddr(ldAddr), .ldSize(ldSize),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize),
    .chkValid(chkValid), .chkReg(chkReg), .chkClear(chkClear),
    .chkHit(chkHit)
  );

  // Behavioural model: an unordered list of live entries with allocation stamps.
  typedef struct {
    int     r;
    longint a;
    int     sz;
    int     stamp;
  } ent_t;
  ent_t mq[$];
  int   stampCtr = 0;

  function automatic bit modelHas(int r);
    foreach (mq[i]) if (mq[i].r == r) return 1;
    return 0;
  endfunction

  function automatic bit rangesMeet(longint a, int asz, longint b, int bsz);
    return (a < b + (64'd1 << bsz)) && (b < a + (64'd1 << asz));
  endfunction

  function automatic void modelUpdate(bit ld, int lr, longint la, int ls,
                                      bit st, longint sa, int ss,
                                      bit ck, int cr, bit cc, bit fl);
    bit hadHit;
    int cnt;
    int oldest;
    hadHit = ck && modelHas(cr);
    if (fl) begin
      mq.delete();
      return;
    end
    if (st) begin
      for (int i = mq.size() - 1; i >= 0; i--)
        if (rangesMeet(mq[i].a, mq[i].sz, sa, ss)) mq.delete(i);
    end
    if (hadHit && cc) begin
      for (int i = mq.size() - 1; i >= 0; i--)
        if (mq[i].r == cr) mq.delete(i);
    end
    if (ld) begin
      for (int i = mq.size() - 1; i >= 0; i--)
        if (mq[i].r == lr) mq.delete(i);
      cnt = 0;
      oldest = -1;
      foreach (mq[i]) begin
        if ((mq[i].r % 16) == (lr % 16)) begin
          cnt++;
          if (oldest < 0 || mq[i].stamp < mq[oldest].stamp) oldest = i;
        end
      end
      if (cnt >= 2) mq.delete(oldest);
      mq.push_back('{r: lr, a: la, sz: ls, stamp: stampCtr});
      stampCtr++;
    end
  endfunction

  task automatic step(bit ld, int lr, longint la, int ls,
                      bit st, longint sa, int ss,
                      bit ck, int cr, bit cc, bit fl, string tag);
    bit expHit;
    ldValid = ld;  ldReg = 7'(lr);  ldAddr = 32'(la);  ldSize = 2'(ls);
    stValid = st;  stAddr = 32'(sa);  stSize = 2'(ss);
    chkValid = ck; chkReg = 7'(cr); chkClear = cc; flush = fl;
    #1;
    expHit = ck && modelHas(cr);
    checks++;
    if (chkHit !== expHit) begin
      failures++;
      $display("FAIL %s: chkHit reg=%0d actual=%b expected=%b", tag, cr, chkHit, expHit);
    end
    @(posedge clk);
    modelUpdate(ld, lr, la, ls, st, sa, ss, ck, cr, cc, fl);
    @(negedge clk);
  endtask

  task automatic doLoad(int r, longint a, int s, string tag);
    step(1, r, a, s, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic doStore(longint a, int s, string tag);
    step(0, 0, 0, 0, 1, a, s, 0, 0, 0, 0, tag);
  endtask
  task automatic doCheck(int r, bit clr, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, r, clr, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state: checks during and after reset miss (R1)
    step(0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 0, "R1");
    rstN = 1'b1;
    doCheck(5, 0, "R1");
    doCheck(0, 0, "R1");

    // R3: same-cycle load and check see the old contents
    step(1, 5, 'h100, 2, 0, 0, 0, 1, 5, 0, 0, "R3");
    doCheck(5, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 0, 5, 0, 0, "R3");

    // R4: adjacent stores keep the entry, an overlapping one kills it
    doStore('h104, 0, "R4");
    doCheck(5, 0, "R4");
    doStore('hFF, 0, "R4");
    doCheck(5, 0, "R4");
    doStore('hFE, 2, "R4");
    doCheck(5, 0, "R4");

    // R5: load and overlapping store in the same cycle
    step(1, 7, 'h200, 3, 1, 'h200, 0, 0, 0, 0, 0, "R5");
    doCheck(7, 0, "R5");

    // R6: same set, different upper bits
    doLoad(3, 'h10, 0, "R6");
    doLoad(19, 'h20, 0, "R6");
    doCheck(35, 0, "R6");
    doCheck(3, 0, "R6");
    doCheck(19, 0, "R6");

    // R7: reload in place keeps the other way, and moves the address
    doLoad(3, 'h30, 1, "R7");
    doCheck(19, 0, "R7");
    doStore('h10, 0, "R7");
    doCheck(3, 0, "R7");

    // R8: full set evicts the least recently allocated way (reg 19)
    doLoad(35, 'h40, 0, "R8");
    doCheck(19, 0, "R8");
    doCheck(3, 0, "R8");
    doCheck(35, 0, "R8");

    // R8: a same-cycle store kill frees a way, so neither live entry is evicted
    doStore('h40, 0, "R8");
    doLoad(35, 'h50, 0, "R8");
    step(1, 51, 'h60, 0, 1, 'h30, 0, 0, 0, 0, 0, "R8");
    doCheck(35, 0, "R8");
    doCheck(51, 0, "R8");
    doCheck(3, 0, "R8");

    // R9: consuming check versus plain check
    doCheck(35, 1, "R9");
    doCheck(35, 0, "R9");
    doCheck(51, 0, "R9");
    doCheck(51, 0, "R9");

    // R1: flush beats a same-cycle load
    step(1, 9, 'h80, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    doCheck(51, 0, "R1");
    doCheck(9, 0, "R1");

    // Mixed random traffic compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 3) == 0, $urandom % 40, $urandom % 64, $urandom % 4,
           ($urandom % 4) == 0, $urandom % 64, $urandom % 4,
           ($urandom % 4) != 0, $urandom % 40, ($urandom % 3) == 0,
           ($urandom % 97) == 0, "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule